// File: doc/BRIEF.md
# Receive Interrupt Coalescing Controller

This block sits between the receive DMA completion path and the host interrupt line. Each received packet shows up as a one-cycle completion pulse. Rather than interrupting the host once per packet, the block can gather packets into a batch. It raises one level interrupt when either of two things happens first: the batch reaches a programmed packet count, or the oldest packet in the batch has waited a programmed number of cycles. With batching switched off, every packet raises the interrupt.

The interrupt stays high until the host acknowledges it. The acknowledge closes the batch and clears the pending count. A packet that completes in the same cycle as the acknowledge opens the next batch. The count threshold, the timeout and the batching enable can be changed at run time. New values are taken up only between batches, so a batch that is already open is never judged against a mix of old and new settings, and no pending count is lost.

Top module: `rx_irq_coalescer`

## Requirements
- R1: After reset, `irq` is low and `pend_cnt` is 0. Until a first setting is loaded, the active settings behave as threshold 1 and timeout 1.
- R2: With `cfg_blank_en` low in the loaded settings, a completion pulse sampled at clock edge k makes `irq` high after edge k, whatever `cfg_pkt_thresh` holds.
- R3: With batching enabled and a loaded threshold N ≥ 2, `irq` stays low while fewer than N packets are pending. `irq` rises after the edge that samples the Nth pulse, and `pend_cnt` then reads N.
- R4: With batching enabled and a loaded timeout T, when the first packet of a batch is counted at edge k and the count threshold is not reached, `irq` rises after edge k+T and not before.
- R5: A loaded threshold of 0 or 1 gives one interrupt per packet, as in R2.
- R6: Once high, `irq` stays high until `irq_ack` is sampled high. An `irq_ack` sampled while `irq` is low has no effect on `pend_cnt` or `irq`.
- R7: While `irq` is high, `pend_cnt` keeps counting further packets. An acknowledge while `irq` is high sets `pend_cnt` to 0, or to 1 when a completion pulse is sampled at the same edge. That packet starts the next batch and is judged against the loaded threshold and timeout.
- R8: The settings inputs are loaded on every clock edge at which `pend_cnt` is 0 and `irq` is low, and are ignored at all other edges. A change made while a batch is open does not alter that batch and does not disturb `pend_cnt`.
- R9: `pend_cnt` saturates at 2^CNT_W−1. It never wraps to a lower value without an acknowledge.
- R10: A loaded timeout of 0 acts as a timeout of 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_done | input | 1 | One-cycle pulse per completed received packet |
| irq_ack | input | 1 | Host acknowledge of the interrupt |
| cfg_blank_en | input | 1 | 1 = batch packets, 0 = interrupt per packet |
| cfg_pkt_thresh | input | THR_W | Packet count that closes a batch |
| cfg_timeout | input | TMO_W | Cycles the first pending packet may wait |
| irq | output | 1 | Level receive interrupt |
| pend_cnt | output | CNT_W | Packets counted since the last acknowledge |

## Verification
The bench targets a packet that arrives in the same cycle as the acknowledge. A design that drops it loses a packet, and a design that keeps the old count never lets the interrupt fall. The timeout is checked cycle by cycle on both sides of its edge, including the value 0, to catch a counter that is off by one or that starts on the wrong cycle. The settings are also changed in the middle of a batch. A design that loads them there fires early, which shows up as `irq` rising on the second packet against a threshold of three. Finally, the bench drives more than 2^CNT_W packets without an acknowledge. A wrapping counter would then show a small `pend_cnt`.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
   // Default widths shared by the block and its bench.
   localparam int unsigned DEF_CNT_W = 8;
   localparam int unsigned DEF_THR_W = 8;
   localparam int unsigned DEF_TMO_W = 16;

   // Reasons for the interrupt to be high in a given cycle.
   typedef enum logic [1:0] {
      FIRE_NONE    = 2'd0,
      FIRE_COUNT   = 2'd1,
      FIRE_TIMEOUT = 2'd2,
      FIRE_HOLD    = 2'd3
   } fire_src_e;
endpackage

// File: rtl/rxc_cfg_shadow.sv
module rxc_cfg_shadow #(
   parameter int unsigned THR_W = 8,
   parameter int unsigned TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             blank_en_in,
   input  logic [THR_W-1:0] thr_in,
   input  logic [TMO_W-1:0] tmo_in,
   output logic [THR_W-1:0] thr_eff,
   output logic [TMO_W-1:0] tmo_eff
);
   localparam logic [THR_W-1:0] THR_ONE = THR_W'(1);
   localparam logic [TMO_W-1:0] TMO_ONE = TMO_W'(1);

   logic [THR_W-1:0] thr_d;
   logic [TMO_W-1:0] tmo_d;

   // Fold the disable and the zero values into the stored threshold.
   always_comb begin
      if (!blank_en_in || thr_in == '0) thr_d = THR_ONE;
      else                              thr_d = thr_in;
      if (tmo_in == '0) tmo_d = TMO_ONE;
      else              tmo_d = tmo_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_eff <= THR_ONE;
         tmo_eff <= TMO_ONE;
      end else if (load) begin
         thr_eff <= thr_d;
         tmo_eff <= tmo_d;
      end
   end
endmodule

// File: rtl/rxc_batch_counter.sv
module rxc_batch_counter #(
   parameter int unsigned CNT_W    = 8,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             clr,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cnt_nxt
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0] inc_val;

   generate
      if (SATURATE) begin : g_sat
         assign inc_val = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_ONE;
      end else begin : g_wrap
         assign inc_val = cnt_q + CNT_ONE;
      end
   endgenerate

   // A clear closes the batch; a same-cycle packet opens the next one.
   always_comb begin
      if (clr)      cnt_nxt = inc ? CNT_ONE : '0;
      else if (inc) cnt_nxt = inc_val;
      else          cnt_nxt = cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_nxt;
   end
endmodule

// File: rtl/rxc_idle_timer.sv
module rxc_idle_timer #(
   parameter int unsigned TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             waiting,
   input  logic             clear,
   input  logic [TMO_W-1:0] limit,
   output logic             expire
);
   localparam logic [TMO_W-1:0] TMO_ONE = TMO_W'(1);

   logic [TMO_W-1:0] age_q;

   // limit is at least 1, so limit-1 never underflows.
   assign expire = waiting && (age_q >= (limit - TMO_ONE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 age_q <= '0;
      else if (!waiting || clear) age_q <= '0;
      else                        age_q <= age_q + TMO_ONE;
   end
endmodule

// File: rtl/rx_irq_coalescer.sv
module rx_irq_coalescer #(
   parameter int unsigned CNT_W = rxc_pkg::DEF_CNT_W,
   parameter int unsigned THR_W = rxc_pkg::DEF_THR_W,
   parameter int unsigned TMO_W = rxc_pkg::DEF_TMO_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pkt_done,
   input  logic             irq_ack,
   input  logic             cfg_blank_en,
   input  logic [THR_W-1:0] cfg_pkt_thresh,
   input  logic [TMO_W-1:0] cfg_timeout,
   output logic             irq,
   output logic [CNT_W-1:0] pend_cnt
);
   import rxc_pkg::*;

   generate
      if (THR_W > CNT_W) begin : g_bad_thr
         $error("THR_W must not exceed CNT_W");
      end
      if (CNT_W < 1 || TMO_W < 1) begin : g_bad_w
         $error("CNT_W and TMO_W must be at least 1");
      end
   endgenerate

   logic             irq_q;
   logic             ack_v;
   logic             batch_idle;
   logic             waiting;
   logic             cnt_hit;
   logic             tmo_hit;
   logic             irq_d;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;
   logic [THR_W-1:0] thr_eff;
   logic [TMO_W-1:0] tmo_eff;
   logic [CNT_W-1:0] thr_ext;
   fire_src_e        fire_src;

   assign ack_v      = irq_ack & irq_q;
   assign batch_idle = (cnt_q == '0) & ~irq_q;
   assign waiting    = (cnt_q != '0) & ~irq_q;
   assign thr_ext    = CNT_W'(thr_eff);

   rxc_cfg_shadow #(.THR_W(THR_W), .TMO_W(TMO_W)) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (batch_idle),
      .blank_en_in(cfg_blank_en),
      .thr_in     (cfg_pkt_thresh),
      .tmo_in     (cfg_timeout),
      .thr_eff    (thr_eff),
      .tmo_eff    (tmo_eff)
   );

   rxc_batch_counter #(.CNT_W(CNT_W), .SATURATE(1'b1)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc    (pkt_done),
      .clr    (ack_v),
      .cnt_q  (cnt_q),
      .cnt_nxt(cnt_nxt)
   );

   rxc_idle_timer #(.TMO_W(TMO_W)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .waiting(waiting),
      .clear  (irq_d),
      .limit  (tmo_eff),
      .expire (tmo_hit)
   );

   // thr_eff is at least 1, so a hit implies a non-empty batch.
   assign cnt_hit = (cnt_nxt >= thr_ext);

   always_comb begin
      if (irq_q && !ack_v) fire_src = FIRE_HOLD;
      else if (cnt_hit)    fire_src = FIRE_COUNT;
      else if (tmo_hit)    fire_src = FIRE_TIMEOUT;
      else                 fire_src = FIRE_NONE;
   end

   assign irq_d = (fire_src != FIRE_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= irq_d;
   end

   assign irq      = irq_q;
   assign pend_cnt = cnt_q;
endmodule

// File: rtl/rx_irq_coalescer_chk.sv
module rx_irq_coalescer_chk #(
   parameter int unsigned CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pkt_done,
   input logic             irq_ack,
   input logic             irq,
   input logic [CNT_W-1:0] pend_cnt
);
   // R6
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !irq_ack |=> irq);

   // R6
   ack_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq && irq_ack && !pkt_done |=> pend_cnt == $past(pend_cnt));

   // R7
   ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq && irq_ack |=> pend_cnt == CNT_W'($past(pkt_done)));

   // R3
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> pend_cnt != '0);

   // R9
   no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq && irq_ack) |=> pend_cnt >= $past(pend_cnt));
endmodule

bind rx_irq_coalescer rx_irq_coalescer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .pkt_done(pkt_done),
   .irq_ack (irq_ack),
   .irq     (irq),
   .pend_cnt(pend_cnt)
);

// File: tb/rx_irq_coalescer_test.sv
module rx_irq_coalescer_test;
   localparam int CNT_W = 8;
   localparam int THR_W = 8;
   localparam int TMO_W = 16;
   localparam int PMAX  = (1 << CNT_W) - 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             pkt_done = 1'b0;
   logic             irq_ack = 1'b0;
   logic             cfg_blank_en = 1'b0;
   logic [THR_W-1:0] cfg_pkt_thresh = '0;
   logic [TMO_W-1:0] cfg_timeout = '0;
   logic             irq;
   logic [CNT_W-1:0] pend_cnt;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   string cur_req = "R1";

   // Reference model state
   int  m_pend = 0;
   bit  m_irq = 0;
   int  m_age = 0;
   int  a_thr = 1;
   int  a_tmo = 1;

   always #4 clk = ~clk;

   rx_irq_coalescer #(.CNT_W(CNT_W), .THR_W(THR_W), .TMO_W(TMO_W)) uut (
      .clk(clk), .rst_n(rst_n), .pkt_done(pkt_done), .irq_ack(irq_ack),
      .cfg_blank_en(cfg_blank_en), .cfg_pkt_thresh(cfg_pkt_thresh),
      .cfg_timeout(cfg_timeout), .irq(irq), .pend_cnt(pend_cnt)
   );

   // Behavioural model, advanced on each rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_pend = 0; m_irq = 0; m_age = 0; a_thr = 1; a_tmo = 1;
      end else begin
         bit ackv, wait_s, tfire, nirq;
         int np;
         ackv   = irq_ack && m_irq;
         wait_s = (m_pend != 0) && !m_irq;
         if (ackv)          np = pkt_done ? 1 : 0;
         else if (pkt_done) np = (m_pend < PMAX) ? m_pend + 1 : m_pend;
         else               np = m_pend;
         tfire = wait_s && (m_age + 1 >= a_tmo);
         nirq  = (m_irq && !ackv) || (np >= a_thr) || tfire;
         if (m_pend == 0 && !m_irq) begin
            a_thr = (!cfg_blank_en || cfg_pkt_thresh == 0) ? 1 : int'(cfg_pkt_thresh);
            a_tmo = (cfg_timeout == 0) ? 1 : int'(cfg_timeout);
         end
         m_age  = (wait_s && !nirq) ? m_age + 1 : 0;
         m_pend = np;
         m_irq  = nirq;
      end
   end

   // Every-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (irq !== m_irq || int'(pend_cnt) != m_pend) begin
            errors++;
            $display("FAIL %s: cycle %0d irq=%0b pend=%0d expected irq=%0b pend=%0d",
                     cur_req, cyc, irq, pend_cnt, m_irq, m_pend);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         errors++;
         $display("FAIL watchdog: run did not finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic step(input bit p, input bit a);
      @(negedge clk);
      pkt_done = p;
      irq_ack  = a;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0);
   endtask

   task automatic chk(input string req, input bit exp_irq, input int exp_pend);
      checks++;
      if (irq !== exp_irq || int'(pend_cnt) != exp_pend) begin
         errors++;
         $display("FAIL %s: irq=%0b pend=%0d expected irq=%0b pend=%0d",
                  req, irq, pend_cnt, exp_irq, exp_pend);
      end
   endtask

   task automatic setcfg(input bit en, input int thr, input int tmo);
      cfg_blank_en   = en;
      cfg_pkt_thresh = THR_W'(thr);
      cfg_timeout    = TMO_W'(tmo);
   endtask

   initial begin
      setcfg(0, 5, 50);
      repeat (3) @(negedge clk);
      cur_req = "R1";
      chk("R1", 0, 0);
      rst_n = 1'b1;
      idle(3);
      chk("R1", 0, 0);

      // R2: per packet with batching off, threshold input ignored
      cur_req = "R2";
      step(1, 0); step(0, 0);
      chk("R2", 1, 1);
      idle(2);
      chk("R6", 1, 1);
      step(0, 1); step(0, 0);
      chk("R7", 0, 0);

      // R3: threshold 4
      cur_req = "R3";
      setcfg(1, 4, 1000);
      idle(3);
      for (int i = 0; i < 3; i++) begin step(1, 0); step(0, 0); end
      chk("R3", 0, 3);
      step(1, 0); step(0, 0);
      chk("R3", 1, 4);
      step(1, 0); step(0, 0);
      chk("R7", 1, 5);

      // R7: same-cycle packet and acknowledge
      cur_req = "R7";
      step(1, 1); step(0, 0);
      chk("R7", 0, 1);
      // R6: acknowledge while low is ignored
      cur_req = "R6";
      step(0, 1); step(0, 0);
      chk("R6", 0, 1);
      for (int i = 0; i < 3; i++) begin step(1, 0); step(0, 0); end
      chk("R3", 1, 4);
      step(0, 1); idle(2);

      // R4: timeout 10 with threshold 8
      cur_req = "R4";
      setcfg(1, 8, 10);
      idle(3);
      step(1, 0);
      for (int i = 0; i < 10; i++) step(0, 0);
      chk("R4", 0, 1);
      step(0, 0);
      chk("R4", 1, 1);
      step(0, 1); idle(2);

      // R10: timeout 0 acts as 1
      cur_req = "R10";
      setcfg(1, 8, 0);
      idle(3);
      step(1, 0); step(0, 0);
      chk("R10", 0, 1);
      step(0, 0);
      chk("R10", 1, 1);
      step(0, 1); idle(2);

      // R5: thresholds 0 and 1
      cur_req = "R5";
      setcfg(1, 0, 500);
      idle(3);
      step(1, 0); step(0, 0);
      chk("R5", 1, 1);
      step(0, 1); idle(2);
      setcfg(1, 1, 500);
      idle(3);
      step(1, 0); step(0, 0);
      chk("R5", 1, 1);
      step(0, 1); idle(2);

      // R8: change mid-batch must wait for the batch to close
      cur_req = "R8";
      setcfg(1, 3, 1000);
      idle(3);
      step(1, 0); step(0, 0);
      setcfg(0, 1, 1000);
      step(1, 0); step(0, 0);
      chk("R8", 0, 2);
      step(1, 0); step(0, 0);
      chk("R8", 1, 3);
      step(0, 1); idle(2);
      step(1, 0); step(0, 0);
      chk("R8", 1, 1);
      step(0, 1); idle(2);

      // R9: saturation without acknowledge
      cur_req = "R9";
      setcfg(0, 1, 1000);
      idle(2);
      for (int i = 0; i < PMAX + 45; i++) step(1, 0);
      step(0, 0);
      chk("R9", 1, PMAX);
      step(0, 1); idle(2);
      chk("R9", 0, 0);

      // Mixed traffic with settings changes
      cur_req = "R3/R4/R8 mixed";
      for (int i = 0; i < 3000; i++) begin
         if ($urandom_range(0, 99) < 3)
            setcfg($urandom_range(0, 1), $urandom_range(0, 6), $urandom_range(0, 12));
         step($urandom_range(0, 99) < 30, irq && ($urandom_range(0, 99) < 20));
      end
      idle(2);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule